// File: doc/BRIEF.md
# Rotational Position and Latency Timer

This block keeps the angular position of a continuously spinning head-per-track disk as a word index on a 2048-word track. A prescaler counts system clocks up to a programmable inter-word interval, and each time the interval elapses the word index moves on by one, wrapping from the last word back to word zero. The current index is presented on an output for a host status read. There is no input that loads or writes it, so the disk position can only change by rotation.

When the controller requests a transfer, the block takes the low bits of the disk address as the target word. It computes how many word times remain until that word passes under the heads, as a distance modulo the track length. It then raises a one-cycle start strobe at the word boundary that ends the target word. While the controller keeps its active input high, the block then raises a one-cycle word strobe at every later word boundary, one interval apart. An abort input, driven from a controller clear, cancels a pending start or a running stream of word strobes at once. Data movement and register decode live elsewhere.

Top module: `rpl_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the position output reads 0 and neither strobe is asserted.
- R2: The position output advances by exactly one each time the prescaler has counted `interval` clock cycles, and holds its value in every other cycle.
- R3: After word 2047 the position returns to 0.
- R4: An interval setting of 0 is taken as 1, so the position advances on every clock.
- R5: A start request accepted while idle latches bits [10:0] of the target address; the upper address bits have no effect. The start strobe is high for exactly one cycle, in the clock cycle where the position output equals the target and the position advances at the next edge. That is (target - position) mod 2048 word times after the request.
- R6: A target equal to the position at the time of the request gives the start strobe at the very next word boundary, not one revolution later.
- R7: After the start strobe, while active is high, a one-cycle word strobe occurs at each later word boundary, exactly one interval apart.
- R8: When active is low after the start strobe, the transfer ends, and no word strobe occurs until a new start.
- R9: Abort suppresses both strobes in the cycle where it is high, and it cancels a pending start and a running transfer, so no strobe follows without a new start.
- R10: A start request made while a start is pending or a transfer is running is ignored; the pending start keeps its original target.
- R11: No strobe occurs without a start request, and the two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_i | input | 24 | Clocks per word time (0 taken as 1) |
| target_i | input | 16 | Disk address; bits [10:0] give the target word |
| start_i | input | 1 | Transfer start request |
| abort_i | input | 1 | Cancel pending start or running transfer |
| active_i | input | 1 | Transfer still wants words |
| pos_o | output | 11 | Current word position under the heads |
| start_stb_o | output | 1 | First word of the transfer is under the heads |
| word_stb_o | output | 1 | A further word of the transfer is under the heads |

## Verification
The bench aims at the modular distance. A target just behind the heads must wait almost a full revolution, so a design that skips the wrap correction would fire at once or would never fire. A zero-distance request must fire at the next boundary, which catches a design that waits a full extra turn. The exact strobe cycle is measured from a known prescaler phase, so an off-by-one in the prescaler terminal count or in the latency count shows up as a strobe one cycle or one word early or late. Other tests cover a zero interval, a second start while busy, and an abort in the very cycle of a word strobe: a design that latched the later target, stalled on zero, or let the strobe through for one cycle would fail them.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

  typedef enum logic [1:0] {
    SCH_IDLE = 2'd0,
    SCH_WAIT = 2'd1,
    SCH_XFER = 2'd2
  } sched_state_t;

endpackage

// File: rtl/rpl_prescaler.sv
module rpl_prescaler #(
  parameter int IVL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] interval_i,
  output logic             tick_o
);

  // terminal count of the prescaler; a zero interval behaves like one
  function automatic logic [IVL_W-1:0] term_count(input logic [IVL_W-1:0] ivl);
    if (ivl == '0) return '0;
    return ivl - 1'b1;
  endfunction

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] term_w;

  assign term_w = term_count(interval_i);
  // >= so that lowering the interval mid-count cannot strand the counter
  assign tick_o = (cnt_q >= term_w);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rpl_position.sv
module rpl_position #(
  parameter int WORDS = 2048,
  localparam int POS_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] pos_nxt_o
);

  function automatic logic [POS_W-1:0] wrap_inc(input logic [POS_W-1:0] p);
    if (p == POS_W'(WORDS - 1)) return '0;
    return p + 1'b1;
  endfunction

  logic [POS_W-1:0] pos_q;

  assign pos_nxt_o = wrap_inc(pos_q);
  assign pos_o     = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pos_q <= '0;
    else if (tick_i) pos_q <= pos_nxt_o;
  end

endmodule

// File: rtl/rpl_sched.sv
module rpl_sched
  import rpl_pkg::*;
#(
  parameter int WORDS  = 2048,
  parameter int ADDR_W = 16,
  localparam int POS_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [POS_W-1:0]  pos_nxt_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              active_i,
  output logic              start_stb_o,
  output logic              word_stb_o,
  output sched_state_t      state_o,
  output logic [POS_W-1:0]  tgt_o
);

  // word times from position p until word t is under the heads
  function automatic logic [POS_W-1:0] word_dist(input logic [POS_W-1:0] t,
                                                 input logic [POS_W-1:0] p);
    logic [POS_W:0] d;
    if (t >= p) d = {1'b0, t} - {1'b0, p};
    else        d = {1'b0, t} + (POS_W+1)'(WORDS) - {1'b0, p};
    return d[POS_W-1:0];
  endfunction

  sched_state_t     st_q;
  logic [POS_W-1:0] rem_q;
  logic [POS_W-1:0] tgt_q;
  logic [POS_W-1:0] base_w;
  logic             accept_w;
  logic             fire_w;

  // the position that holds after this edge is the base of the distance
  assign base_w   = tick_i ? pos_nxt_i : pos_i;
  assign accept_w = (st_q == SCH_IDLE) && start_i && !abort_i;
  assign fire_w   = (st_q == SCH_WAIT) && tick_i && (rem_q == '0) && !abort_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SCH_IDLE;
      rem_q <= '0;
      tgt_q <= '0;
    end else begin
      unique case (st_q)
        SCH_IDLE: begin
          if (accept_w) begin
            tgt_q <= target_i[POS_W-1:0];
            rem_q <= word_dist(target_i[POS_W-1:0], base_w);
            st_q  <= SCH_WAIT;
          end
        end
        SCH_WAIT: begin
          if (abort_i)     st_q <= SCH_IDLE;
          else if (fire_w) st_q <= SCH_XFER;
          else if (tick_i) rem_q <= rem_q - 1'b1;
        end
        SCH_XFER: begin
          if (abort_i || !active_i) st_q <= SCH_IDLE;
        end
        default: st_q <= SCH_IDLE;
      endcase
    end
  end

  assign start_stb_o = fire_w;
  assign word_stb_o  = (st_q == SCH_XFER) && tick_i && active_i && !abort_i;
  assign state_o     = st_q;
  assign tgt_o       = tgt_q;

endmodule

// File: rtl/rpl_timer.sv
module rpl_timer
  import rpl_pkg::*;
#(
  parameter int WORDS  = 2048,
  parameter int ADDR_W = 16,
  parameter int IVL_W  = 24,
  localparam int POS_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  interval_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              active_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              start_stb_o,
  output logic              word_stb_o
);

  logic             tick_w;
  logic [POS_W-1:0] pos_w;
  logic [POS_W-1:0] pos_nxt_w;
  logic [POS_W-1:0] tgt_w;
  sched_state_t     state_w;

  rpl_prescaler #(.IVL_W(IVL_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .interval_i (interval_i),
    .tick_o     (tick_w)
  );

  rpl_position #(.WORDS(WORDS)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_w),
    .pos_o     (pos_w),
    .pos_nxt_o (pos_nxt_w)
  );

  rpl_sched #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_w),
    .pos_i       (pos_w),
    .pos_nxt_i   (pos_nxt_w),
    .target_i    (target_i),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .active_i    (active_i),
    .start_stb_o (start_stb_o),
    .word_stb_o  (word_stb_o),
    .state_o     (state_w),
    .tgt_o       (tgt_w)
  );

  assign pos_o = pos_w;

endmodule

// File: rtl/rpl_timer_chk.sv
module rpl_timer_chk
  import rpl_pkg::*;
#(
  parameter int WORDS = 2048,
  localparam int POS_W = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] tgt,
  input sched_state_t     state,
  input logic             start_i,
  input logic             abort_i,
  input logic             start_stb,
  input logic             word_stb
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pos != $past(pos));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos == POS_W'(WORDS - 1)) |=> pos == '0);

  assert_first_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> (tick && pos == tgt));

  assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb);

  assert_word_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> tick);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> (!start_stb && !word_stb));

  assert_busy_keeps_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SCH_IDLE && start_i) |=> $stable(tgt));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_stb && word_stb));

endmodule

bind rpl_timer rpl_timer_chk #(.WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .pos       (pos_w),
  .tgt       (tgt_w),
  .state     (state_w),
  .start_i   (start_i),
  .abort_i   (abort_i),
  .start_stb (start_stb_o),
  .word_stb  (word_stb_o)
);

// File: tb/sim_rpl_timer.sv
`timescale 1ns/1ps
module sim_rpl_timer;

  localparam int WORDS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] interval_i = 24'd1;
  logic [15:0] target_i = '0;
  logic        start_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        active_i = 1'b0;
  logic [10:0] pos_o;
  logic        start_stb_o;
  logic        word_stb_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rpl_timer u0 (
    .clk(clk), .rst_n(rst_n), .interval_i(interval_i), .target_i(target_i),
    .start_i(start_i), .abort_i(abort_i), .active_i(active_i),
    .pos_o(pos_o), .start_stb_o(start_stb_o), .word_stb_o(word_stb_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_change();
    logic [10:0] p;
    p = pos_o;
    do @(negedge clk); while (pos_o == p);
  endtask

  task automatic pulse_start(input logic [15:0] tgt);
    target_i = tgt;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  // count samples until start strobe, with a bound
  task automatic wait_start(input int limit, output int n);
    n = 0;
    while (!start_stb_o && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pos_o == 0, "R1 pos in reset", pos_o, 0);
    chk(!start_stb_o && !word_stb_o, "R1 strobes in reset", start_stb_o + word_stb_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!start_stb_o && !word_stb_o, "R1 strobes after reset", start_stb_o + word_stb_o, 0);
  endtask

  task automatic t_interval(input int k, input int exp, input string req);
    int n;
    logic [10:0] p0;
    interval_i = 24'(k);
    sync_change();
    sync_change();
    p0 = pos_o;
    n = 0;
    do begin @(negedge clk); n++; end while (pos_o == p0 && n < 1000);
    chk(n == exp, req, n, exp);
    chk(pos_o == 11'(p0 + 1), {req, " step"}, pos_o, 11'(p0 + 1));
  endtask

  task automatic t_wrap();
    int n = 0;
    interval_i = 24'd1;
    while (pos_o != 11'd2047 && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(pos_o == 0, "R3 wrap to zero", pos_o, 0);
  endtask

  task automatic t_idle();
    int seen = 0;
    active_i = 1'b1;
    interval_i = 24'd2;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (start_stb_o || word_stb_o) seen++;
    end
    chk(seen == 0, "R11 no strobe without start", seen, 0);
    active_i = 1'b0;
  endtask

  // exact-cycle latency check from a known prescaler phase
  task automatic t_latency(input int k, input int offset, input logic [4:0] upper,
                           input string req);
    int n, exp;
    logic [10:0] t;
    active_i = 1'b0;
    interval_i = 24'(k);
    sync_change();
    sync_change();
    t = 11'(pos_o + offset);
    exp = offset * k + k - 1;
    target_i = {upper, t};
    start_i = 1'b1;
    if (exp == 0) begin
      chk(0, {req, " bad setup"}, 0, 1);
    end
    @(negedge clk);
    start_i = 1'b0;
    wait_start(exp + 2 * k + 10, n);
    n = n + 1;
    chk(start_stb_o && n == exp, {req, " delay"}, n, exp);
    chk(pos_o == t, {req, " pos at strobe"}, pos_o, t);
    @(negedge clk);
    chk(!start_stb_o, {req, " one cycle"}, start_stb_o, 0);
    chk(pos_o == 11'(t + 1), {req, " boundary"}, pos_o, 11'(t + 1));
    for (int i = 0; i < 3; i++) @(negedge clk);
  endtask

  task automatic t_words();
    int n, cnt;
    interval_i = 24'd4;
    active_i = 1'b1;
    sync_change();
    pulse_start(16'(pos_o + 3));
    wait_start(100, n);
    chk(start_stb_o, "R7 start seen", start_stb_o, 1);
    for (int w = 0; w < 6; w++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!word_stb_o && n < 50);
      chk(n == 4, "R7 word spacing", n, 4);
      chk(!start_stb_o, "R11 no start with word", start_stb_o, 0);
    end
    active_i = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (word_stb_o) cnt++;
    end
    active_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (word_stb_o) cnt++;
    end
    chk(cnt == 0, "R8 transfer ended", cnt, 0);
    active_i = 1'b0;
  endtask

  task automatic t_abort_wait();
    int n;
    interval_i = 24'd1;
    @(negedge clk);
    pulse_start(16'(pos_o + 100));
    for (int i = 0; i < 5; i++) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    wait_start(2200, n);
    chk(!start_stb_o, "R9 abort cancels pending start", start_stb_o, 0);
  endtask

  task automatic t_abort_xfer();
    int n, cnt;
    interval_i = 24'd3;
    active_i = 1'b1;
    sync_change();
    pulse_start(16'(pos_o + 2));
    wait_start(100, n);
    n = 0;
    do begin @(negedge clk); n++; end while (!word_stb_o && n < 50);
    chk(word_stb_o, "R7 word before abort", word_stb_o, 1);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(word_stb_o, "R7 next word due", word_stb_o, 1);
    abort_i = 1'b1;
    #1;
    chk(!word_stb_o, "R9 same-cycle suppression", word_stb_o, 0);
    @(negedge clk);
    abort_i = 1'b0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (word_stb_o || start_stb_o) cnt++;
    end
    chk(cnt == 0, "R9 abort ends transfer", cnt, 0);
    active_i = 1'b0;
  endtask

  task automatic t_busy();
    int n;
    logic [10:0] t1;
    interval_i = 24'd1;
    @(negedge clk);
    t1 = 11'(pos_o + 300);
    pulse_start({5'd0, t1});
    for (int i = 0; i < 4; i++) @(negedge clk);
    pulse_start(16'(pos_o + 40));
    wait_start(2200, n);
    chk(start_stb_o && pos_o == t1, "R10 later start ignored", pos_o, t1);
    for (int i = 0; i < 3; i++) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_interval(5, 5, "R2 interval 5");
    t_interval(3, 3, "R2 interval 3");
    t_interval(0, 1, "R4 zero interval");
    t_wrap();
    t_latency(2, 10, 5'd0, "R5 forward");
    t_latency(3, 7, 5'b10110, "R5 upper bits ignored");
    t_latency(2, 2045, 5'd0, "R5 wrap distance");
    t_latency(6, 0, 5'd0, "R6 zero latency");
    t_words();
    t_abort_wait();
    t_abort_xfer();
    t_busy();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule